// File: doc/BRIEF.md
# UART Receiver with Mute-Mode Wakeup

This block is the receive half of an asynchronous serial port. It samples the receive line on a 16x baud tick and checks each start bit at mid-bit. It assembles 8- or 9-bit words, sent least significant bit first, with an optional parity bit, and places each finished word into a receive data register. A not-empty flag marks a waiting word. A parity error flag and an idle-line flag report line conditions. One interrupt output combines the three flags, each through its own enable.

Software can put the receiver into a mute state, for example on a shared multi-drop line where most traffic is meant for other nodes. While muted, finished words change neither the data register nor its flags. Two wakeup methods are available:
- In line-idle mode, the receiver wakes when the line has stayed high for a whole frame time after a word.
- In address mode, the receiver wakes on a word that carries an address mark and whose low bits match the node's own 4-bit address. That word is delivered.

Software changes to the mute state are refused in address mode while an unread word is waiting.

Top module: `uart_rx_mute`

## Requirements
- R1: After reset, rx_data is 0 and rxne, perr, idle, muted and irq are all 0.
- R2: A frame is a low start bit, then N data bits least significant bit first (N=8 when cfg_word9=0, N=9 when cfg_word9=1), then a parity bit when cfg_par_en=1, then a high stop bit. Each bit lasts 16 ticks. The finished word appears on rx_data, zero-extended to 9 bits in 8-bit mode, and rxne goes to 1.
- R3: Every bit value is the majority of its 8th, 9th and 10th samples (tick indices 7, 8 and 9 within the bit). A start bit whose majority is high is dropped, and the receiver waits for the next falling edge.
- R4: rxne is cleared by a one-cycle pulse on rd_data or on clr_rxne. It rises only when a word is delivered.
- R5: With cfg_par_en=1, perr goes to 1 together with a delivered word when the ones count over data plus parity bit is odd (cfg_par_odd=0) or even (cfg_par_odd=1). perr stays set until a clr_perr pulse. Words with correct parity do not clear it.
- R6: idle goes to 1 once when the line has been high and no frame has been in progress for 16*(2+N+P) ticks, where P is 1 with parity. This counts only after at least one word has been received. It does not go to 1 again until another word has been received. It is cleared by a clr_idle pulse.
- R7: While muted=1, a word that does not wake the receiver leaves rx_data, rxne and perr unchanged.
- R8: A one-cycle pulse on mute_wr loads mute_wdata into muted. With cfg_wake_addr=0, an idle-line event clears muted. A receiver muted with no word received since the last idle event stays muted however long the line stays high.
- R9: With cfg_wake_addr=1, a word whose top bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode) and whose bits 3:0 equal cfg_node_addr clears muted and is delivered. Any other word, and any idle-line event, leaves the receiver muted.
- R10: With cfg_wake_addr=1, a mute_wr pulse has no effect while rxne=1.
- R11: irq is 1 exactly when (rxne and ie_rxne) or (perr and ie_perr) or (idle and ie_idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Serial receive line, already synchronous to clk; high when idle |
| os_tick | input | 1 | One-cycle strobe at 16 times the baud rate |
| cfg_word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data bits |
| cfg_par_odd | input | 1 | Parity kind: 0 even, 1 odd |
| cfg_wake_addr | input | 1 | Wakeup method: 0 idle line, 1 address mark |
| cfg_node_addr | input | 4 | Own node address compared with bits 3:0 of address words |
| ie_rxne | input | 1 | Interrupt enable for rxne |
| ie_perr | input | 1 | Interrupt enable for perr |
| ie_idle | input | 1 | Interrupt enable for idle |
| mute_wr | input | 1 | Write strobe for the mute state |
| mute_wdata | input | 1 | Value written to the mute state |
| rd_data | input | 1 | Read strobe for rx_data; clears rxne |
| clr_rxne | input | 1 | Clears rxne |
| clr_perr | input | 1 | Clears perr |
| clr_idle | input | 1 | Clears idle |
| rx_data | output | 9 | Receive data register |
| rxne | output | 1 | Receive data register holds an unread word |
| perr | output | 1 | Parity error flag |
| idle | output | 1 | Idle-line flag |
| muted | output | 1 | Mute state |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the mute corners:
- An address word with a foreign node number, a plain data word with matching low bits, and a 9-bit word whose bit 7 is set but bit 8 is clear. A design that decodes the address mark or the node field wrongly would wake on one of these, or stay asleep on the matching address.
- Writing the mute state while an unread word waits in address mode. A design without that lock would mute itself there.
- Muting with no word received since the last idle event. A design that re-arms idle detection on its own would wake spuriously.
- A short low pulse that must not count as a start bit, and a single inverted sample inside a data bit. Both expose start checking or bit voting at the wrong sample.
- Parity in both senses, and perr that must not clear on a good word.

// File: rtl/uart_rxm_pkg.sv
// Shared types and helpers for the mute-capable UART receiver.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package uart_rxm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Two-out-of-three vote used for every bit decision.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxm_frame_rx.sv
// Frame deserializer: finds a start bit, votes each bit from three mid-bit
// samples and assembles data, parity and stop into one word.
// Assumes rx is synchronous to clk and OSR is a power of two (counter wraps).
module rxm_frame_rx
    import uart_rxm_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int MAXW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            rx,
    input  logic            word9,
    input  logic            par_en,
    input  logic            par_odd,
    output logic            busy,
    output logic            done,
    output logic [MAXW-1:0] word,
    output logic            par_err
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(MAXW + 1);
    localparam logic [CW-1:0] SMP_A = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] SMP_B = CW'(OSR / 2);
    localparam logic [CW-1:0] SMP_C = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] CNT_END = CW'(OSR - 1);

    rx_state_e        st;
    logic [CW-1:0]    cnt;
    logic             s_a, s_b, pbit;
    logic [BW-1:0]    bidx;
    logic [MAXW-1:0]  shreg;
    logic [BW-1:0]    last_bit;
    logic             vote;

    // Index of the final data bit for the selected word length.
    assign last_bit = word9 ? BW'(MAXW - 1) : BW'(MAXW - 2);
    assign vote     = maj3(s_a, s_b, rx);
    assign busy     = (st != ST_IDLE);

    // Bit-timing state machine, advanced only on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            s_a     <= 1'b1;
            s_b     <= 1'b1;
            pbit    <= 1'b0;
            bidx    <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            word    <= '0;
            par_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (st == ST_IDLE) begin
                    if (!rx) begin
                        st    <= ST_START;
                        cnt   <= CW'(1);
                        shreg <= '0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                    if (cnt == SMP_A) s_a <= rx;
                    if (cnt == SMP_B) s_b <= rx;
                    if (cnt == SMP_C) begin
                        case (st)
                            ST_START: if (vote) st <= ST_IDLE;
                            ST_DATA:  shreg[bidx] <= vote;
                            ST_PAR:   pbit <= vote;
                            ST_STOP: begin
                                done    <= 1'b1;
                                word    <= shreg;
                                par_err <= par_en && ((^shreg ^ pbit) != par_odd);
                                st      <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == CNT_END) begin
                        case (st)
                            ST_START: begin
                                st   <= ST_DATA;
                                bidx <= '0;
                            end
                            ST_DATA: begin
                                if (bidx == last_bit) st <= par_en ? ST_PAR : ST_STOP;
                                else                  bidx <= bidx + 1'b1;
                            end
                            ST_PAR:  st <= ST_STOP;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/rxm_idle_det.sv
// Idle-line detector: counts ticks of high, quiet line and raises a one-cycle
// event after a full frame time, at most once per received word.
// Assumes busy is high for the whole of any frame in progress.
module rxm_idle_det #(
    parameter int OSR  = 16,
    parameter int MAXW = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    input  logic busy,
    input  logic word_done,
    input  logic word9,
    input  logic par_en,
    output logic idle_evt
);
    localparam int FMAX = OSR * (MAXW + 3);
    localparam int FW   = $clog2(FMAX + 1);

    logic [FW-1:0] ctr;
    logic [FW-1:0] frame_ticks;
    logic          armed;

    // Frame length in ticks for the current format.
    always_comb begin
        frame_ticks = FW'(OSR * (2 + (word9 ? MAXW : MAXW - 1) + (par_en ? 1 : 0)));
    end

    assign idle_evt = tick && rx && !busy && armed && (ctr == frame_ticks - FW'(1));

    // Quiet-line counter and the arm bit re-set by every received word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr   <= '0;
            armed <= 1'b0;
        end else begin
            if (word_done)     armed <= 1'b1;
            else if (idle_evt) armed <= 1'b0;
            if (tick) begin
                if (busy || !rx)            ctr <= '0;
                else if (ctr != frame_ticks) ctr <= ctr + 1'b1;
            end
        end
    end

    // R6
    idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> !idle_evt);

endmodule

// File: rtl/rxm_mute_ctl.sv
// Mute state: software writes, wakeup by idle line or by matching address
// word, and the decision whether a finished word reaches the data register.
// Assumes word_msb and word_low belong to the word flagged by word_done.
module rxm_mute_ctl #(
    parameter int ADDRW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_addr,
    input  logic [ADDRW-1:0] node_addr,
    input  logic             word_done,
    input  logic             word_msb,
    input  logic [ADDRW-1:0] word_low,
    input  logic             idle_evt,
    input  logic             mute_wr,
    input  logic             mute_wdata,
    input  logic             rxne,
    output logic             muted,
    output logic             deliver
);
    logic addr_hit;
    logic wake;

    assign addr_hit = wake_addr && word_msb && (word_low == node_addr);
    assign wake     = muted && (wake_addr ? (word_done && addr_hit) : idle_evt);
    assign deliver  = word_done && (!muted || addr_hit);

    // Mute register: wakeup first, then guarded software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   muted <= 1'b0;
        else if (wake)                                muted <= 1'b0;
        else if (mute_wr && !(wake_addr && rxne))     muted <= mute_wdata;
    end

    // R10
    mute_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_addr && rxne && mute_wr && !word_done) |=> (muted == $past(muted)));

    // R8
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (muted && !wake_addr && idle_evt) |=> !muted);

    // R9
    addr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (muted && wake_addr && word_done && !word_msb) |-> !deliver);

endmodule

// File: rtl/uart_rx_mute.sv
// Top of the mute-capable UART receiver: data register, status flags and
// interrupt around the deserializer, idle detector and mute control.
// Assumes rx_line is already synchronous and os_tick is a one-cycle strobe.
module uart_rx_mute #(
    parameter int OSR   = 16,
    parameter int MAXW  = 9,
    parameter int ADDRW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic             os_tick,
    input  logic             cfg_word9,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_wake_addr,
    input  logic [ADDRW-1:0] cfg_node_addr,
    input  logic             ie_rxne,
    input  logic             ie_perr,
    input  logic             ie_idle,
    input  logic             mute_wr,
    input  logic             mute_wdata,
    input  logic             rd_data,
    input  logic             clr_rxne,
    input  logic             clr_perr,
    input  logic             clr_idle,
    output logic [MAXW-1:0]  rx_data,
    output logic             rxne,
    output logic             perr,
    output logic             idle,
    output logic             muted,
    output logic             irq
);
    logic            busy, word_done, word_perr, idle_evt, deliver, word_msb;
    logic [MAXW-1:0] word;

    rxm_frame_rx #(.OSR(OSR), .MAXW(MAXW)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_line),
        .word9(cfg_word9), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .busy(busy), .done(word_done), .word(word), .par_err(word_perr)
    );

    rxm_idle_det #(.OSR(OSR), .MAXW(MAXW)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_line), .busy(busy),
        .word_done(word_done), .word9(cfg_word9), .par_en(cfg_par_en),
        .idle_evt(idle_evt)
    );

    assign word_msb = cfg_word9 ? word[MAXW-1] : word[MAXW-2];

    rxm_mute_ctl #(.ADDRW(ADDRW)) u_mute (
        .clk(clk), .rst_n(rst_n), .wake_addr(cfg_wake_addr),
        .node_addr(cfg_node_addr), .word_done(word_done), .word_msb(word_msb),
        .word_low(word[ADDRW-1:0]), .idle_evt(idle_evt), .mute_wr(mute_wr),
        .mute_wdata(mute_wdata), .rxne(rxne), .muted(muted), .deliver(deliver)
    );

    // Data register and flags; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rxne    <= 1'b0;
            perr    <= 1'b0;
            idle    <= 1'b0;
        end else begin
            if (deliver) rx_data <= word;
            if (deliver)                    rxne <= 1'b1;
            else if (rd_data || clr_rxne)   rxne <= 1'b0;
            if (deliver && word_perr)       perr <= 1'b1;
            else if (clr_perr)              perr <= 1'b0;
            if (idle_evt)                   idle <= 1'b1;
            else if (clr_idle)              idle <= 1'b0;
        end
    end

    assign irq = (rxne && ie_rxne) || (perr && ie_perr) || (idle && ie_idle);

    // R4
    rxne_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxne) |-> $past(deliver));

    // R7
    mute_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !deliver) |=> $stable(rx_data));

    // R6
    idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(idle_evt));

endmodule

// File: tb/test_uart_rx_mute.sv
`timescale 1ns/1ps
module test_uart_rx_mute;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1, os_tick = 1'b0;
    logic cfg_word9 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_wake_addr = 0;
    logic [3:0] cfg_node_addr = 4'd0;
    logic ie_rxne = 0, ie_perr = 0, ie_idle = 0;
    logic mute_wr = 0, mute_wdata = 0, rd_data = 0, clr_rxne = 0, clr_perr = 0, clr_idle = 0;
    logic [8:0] rx_data;
    logic rxne, perr, idle, muted, irq;

    int n_checks = 0, n_errors = 0, tdiv = 0;
    bit cmp_en = 0, finished = 0;
    // behavioural reference state
    logic [8:0] m_data = 0;
    bit m_rxne = 0, m_pe = 0, m_idle = 0, m_muted = 0, m_armed = 0;

    uart_rx_mute i_uart_rx_mute (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .cfg_word9(cfg_word9), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_wake_addr(cfg_wake_addr), .cfg_node_addr(cfg_node_addr),
        .ie_rxne(ie_rxne), .ie_perr(ie_perr), .ie_idle(ie_idle),
        .mute_wr(mute_wr), .mute_wdata(mute_wdata), .rd_data(rd_data),
        .clr_rxne(clr_rxne), .clr_perr(clr_perr), .clr_idle(clr_idle),
        .rx_data(rx_data), .rxne(rxne), .perr(perr), .idle(idle),
        .muted(muted), .irq(irq)
    );

    always #5 clk = ~clk;

    // 16x tick every fourth clock, changed away from the sampling edge
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        os_tick = (tdiv == 0);
    end

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic bit m_irq();
        return (m_rxne && ie_rxne) || (m_pe && ie_perr) || (m_idle && ie_idle);
    endfunction

    // every-clock comparison against the reference state
    always @(posedge clk) begin
        #1;
        if (cmp_en && rst_n && !finished) begin
            chk("R2 rx_data", rx_data, m_data);
            chk("R4 rxne", rxne, m_rxne);
            chk("R5 perr", perr, m_pe);
            chk("R6 idle", idle, m_idle);
            chk("R7 muted", muted, m_muted);
            chk("R11 irq", irq, m_irq());
        end
    end

    task automatic model_word(input logic [8:0] w, input bit err);
        bit msb;
        msb = cfg_word9 ? w[8] : w[7];
        if (!m_muted || (cfg_wake_addr && msb && w[3:0] == cfg_node_addr)) begin
            m_muted = 0;
            m_data = w;
            m_rxne = 1;
            if (err) m_pe = 1;
        end
        m_armed = 1;
    endtask

    task automatic model_idle();
        if (m_armed) begin
            m_idle = 1;
            m_armed = 0;
            if (!cfg_wake_addr) m_muted = 0;
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (os_tick !== 1'b1);
        end
    endtask

    // one bit; optionally flip the line for sample index 7 only
    task automatic drive_bit(input logic v, input bit glitch);
        @(negedge clk) rx_line = v;
        for (int idx = 0; idx < 16; idx++) begin
            wait_ticks(1);
            if (glitch && idx == 6) @(negedge clk) rx_line = !v;
            if (glitch && idx == 7) @(negedge clk) rx_line = v;
        end
    endtask

    task automatic send_frame(input logic [8:0] w, input int glitch_bit, input bit pflip);
        int n;
        logic [8:0] d;
        logic p;
        n = cfg_word9 ? 9 : 8;
        d = cfg_word9 ? w : {1'b0, w[7:0]};
        drive_bit(1'b0, 0);
        for (int b = 0; b < n; b++) drive_bit(d[b], glitch_bit == b);
        if (cfg_par_en) begin
            p = (^d) ^ cfg_par_odd ^ pflip;
            drive_bit(p, 0);
        end
        cmp_en = 0;
        drive_bit(1'b1, 0);
        repeat (2) @(negedge clk);
        model_word(d, pflip && cfg_par_en);
        cmp_en = 1;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1;
        @(negedge clk) sig = 0;
    endtask

    task automatic do_read();
        @(negedge clk) rd_data = 1; m_rxne = 0;
        @(negedge clk) rd_data = 0;
    endtask

    task automatic do_clr_perr();
        @(negedge clk) clr_perr = 1; m_pe = 0;
        @(negedge clk) clr_perr = 0;
    endtask

    task automatic do_clr_idle();
        @(negedge clk) clr_idle = 1; m_idle = 0;
        @(negedge clk) clr_idle = 0;
    endtask

    task automatic write_mute(input logic v);
        @(negedge clk) mute_wr = 1; mute_wdata = v;
        if (!(cfg_wake_addr && m_rxne)) m_muted = v;
        @(negedge clk) mute_wr = 0;
    endtask

    function automatic int frame_ticks();
        return 16 * (2 + (cfg_word9 ? 9 : 8) + (cfg_par_en ? 1 : 0));
    endfunction

    // wait past one frame time of high line; the event must not come early
    task automatic idle_window();
        int f;
        f = frame_ticks();
        wait_ticks(f - 12);
        @(negedge clk) chk("R6 idle before frame time", idle, m_idle);
        cmp_en = 0;
        wait_ticks(14);
        repeat (2) @(negedge clk);
        model_idle();
        cmp_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        chk("R1 rxne", rxne, 0);
        chk("R1 perr", perr, 0);
        chk("R1 idle", idle, 0);
        chk("R1 muted", muted, 0);
        chk("R1 irq", irq, 0);
        cmp_en = 1;

        // R2 8-bit word, R4 cleared by read
        send_frame(9'h0A5, -1, 0);
        chk("R2 word 0xA5", rx_data, 9'h0A5);
        chk("R2 rxne set", rxne, 1);
        do_read();
        @(negedge clk) chk("R4 rxne after read", rxne, 0);

        // R4 write-clear, R11 irq from rxne
        ie_rxne = 1;
        send_frame(9'h03C, -1, 0);
        @(negedge clk) chk("R11 irq on rxne", irq, 1);
        @(negedge clk) clr_rxne = 1; m_rxne = 0;
        @(negedge clk) clr_rxne = 0;
        chk("R4 rxne after clear", rxne, 0);
        chk("R4 data kept", rx_data, 9'h03C);

        // R2 9-bit word
        cfg_word9 = 1;
        send_frame(9'h1C3, -1, 0);
        chk("R2 9-bit word", rx_data, 9'h1C3);
        do_read();
        cfg_word9 = 0;

        // R5 parity, even then odd
        cfg_par_en = 1; cfg_par_odd = 0;
        send_frame(9'h05A, -1, 0);
        chk("R5 even ok", perr, 0);
        send_frame(9'h05B, -1, 1);
        chk("R5 even error", perr, 1);
        chk("R5 error word", rx_data, 9'h05B);
        cfg_par_odd = 1;
        send_frame(9'h007, -1, 0);
        chk("R5 sticky on good word", perr, 1);
        do_clr_perr();
        chk("R5 cleared", perr, 0);
        ie_perr = 1; ie_rxne = 0;
        send_frame(9'h007, -1, 1);
        chk("R5 odd error", perr, 1);
        @(negedge clk) chk("R11 irq on perr", irq, 1);
        do_clr_perr();
        ie_perr = 0;
        do_read();
        cfg_par_en = 0; cfg_par_odd = 0;

        // R3 short low pulse, then a flipped sample inside bit 2
        @(negedge clk) rx_line = 0;
        wait_ticks(4);
        @(negedge clk) rx_line = 1;
        wait_ticks(24);
        chk("R3 false start dropped", rxne, 0);
        send_frame(9'h096, 2, 0);
        chk("R3 vote corrects glitch", rx_data, 9'h096);
        do_read();

        // R6 idle after one frame time, once per word
        idle_window();
        chk("R6 idle set", idle, 1);
        ie_idle = 1;
        @(negedge clk) chk("R11 irq on idle", irq, 1);
        do_clr_idle();
        ie_idle = 0;
        wait_ticks(2 * frame_ticks());
        chk("R6 no second idle", idle, 0);

        // R7 and R8 idle-line wakeup
        write_mute(1);
        chk("R8 mute written", muted, 1);
        wait_ticks(2 * frame_ticks());
        chk("R8 no wake without word", muted, 1);
        send_frame(9'h044, -1, 0);
        chk("R7 muted word dropped", rxne, 0);
        chk("R7 data unchanged", rx_data, 9'h096);
        idle_window();
        chk("R8 idle wakes", muted, 0);
        do_clr_idle();

        // R9 and R10 address-mark wakeup
        cfg_wake_addr = 1; cfg_node_addr = 4'd5;
        write_mute(1);
        send_frame(9'h083, -1, 0);
        chk("R9 foreign address", muted, 1);
        send_frame(9'h015, -1, 0);
        chk("R9 data word ignored", rxne, 0);
        send_frame(9'h085, -1, 0);
        chk("R9 own address wakes", muted, 0);
        chk("R9 address delivered", rx_data, 9'h085);
        write_mute(1);
        chk("R10 write locked", muted, 0);
        do_read();
        write_mute(1);
        chk("R10 write after read", muted, 1);
        idle_window();
        chk("R9 idle does not wake", muted, 1);
        do_clr_idle();
        cfg_word9 = 1;
        send_frame(9'h085, -1, 0);
        chk("R9 bit 7 not a mark in 9-bit", muted, 1);
        send_frame(9'h105, -1, 0);
        chk("R9 9-bit address wakes", muted, 0);
        chk("R9 9-bit data", rx_data, 9'h105);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule